// File: doc/BRIEF.md
# Three-Mode 16-Bit Lookup Cell

This block is a small bit-storage cell of sixteen one-bit locations, picked by a 4-bit address and read out combinationally on a single output bit. The contents loaded at reset come from a 16-bit parameter, which stands in for configuration data. A 2-bit mode input is captured while reset is high and held for the rest of operation. It picks one of three behaviours for the same storage:

- a read-only table, which ignores any write request;
- a 16x1 RAM, written on a clock edge;
- a 16-stage serial shift register, with the address picking the tap that drives the output.

In shift mode a serial bit enters location 0 on each enabled clock, and every stored bit moves up one place. The address then sets a delay of 1 to 16 enabled clocks. Location 15 is always available on a cascade output, whatever the mode. A design that needs a small function table, a tiny scratch memory or a programmable delay line can drop in one instance and set the mode once at reset.

Top module: `lut_cell`

## Requirements
- R1: While `rst` is high at a rising clock edge, all 16 locations load from the `INIT` parameter, where bit i of `INIT` goes to location i. After reset, `dout_o` equals `INIT[addr_i]`.
- R2: `dout_o` is the bit at location `addr_i` and follows an address change within the same cycle, with no clock edge needed.
- R3: In lookup mode the contents never change and `wr_en_i` has no effect. Lookup mode is `mode_i` = 2'b00, and the reserved code 2'b11 also acts as lookup mode.
- R4: In RAM mode (`mode_i` = 2'b01), `wr_en_i` high at a rising edge stores `din_i` at location `addr_i`. Before that edge, `dout_o` still shows the old value.
- R5: A RAM-mode write leaves the other 15 locations unchanged.
- R6: In shift mode (`mode_i` = 2'b10), `wr_en_i` high at a rising edge moves location i into location i+1 for i from 0 to 14 and loads `din_i` into location 0.
- R7: In RAM or shift mode, a rising edge with `wr_en_i` low leaves every location unchanged.
- R8: In shift mode, with `addr_i` = k, `dout_o` shows the `din_i` bit that was shifted in k+1 enabled clocks earlier.
- R9: `cascade_o` always equals location 15. In shift mode it therefore carries the bit shifted in 16 enabled clocks earlier.
- R10: `mode_i` is sampled only while `rst` is high. A change on `mode_i` after reset does not change the behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; loads contents and captures mode |
| mode_i | input | 2 | Mode select, sampled during reset only |
| addr_i | input | 4 | Location select for read, RAM write and shift tap |
| din_i | input | 1 | Write data in RAM mode, serial input in shift mode |
| wr_en_i | input | 1 | Write enable in RAM mode, shift enable in shift mode |
| dout_o | output | 1 | Combinational read of the addressed location |
| cascade_o | output | 1 | Location 15, the end of the shift chain |

## Verification
The hardest condition to reach from the ports is a change of `mode_i` after reset. The cell has no output that reports its mode, so the only way to see the captured mode is through how the storage behaves. The stimulus resets the cell in RAM mode, then moves `mode_i` to the shift code and keeps writing. The expected results follow RAM rules, and a cell that re-sampled the mode would visibly shift instead. A second hard case is the write-before-edge window. To cover it, the address, data and enable are set up mid-cycle and the output is checked before the clock edge, to catch any write that shows through early. The tap-delay rule is checked separately: a single one is walked down the chain while the address follows it.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    typedef enum logic [1:0] {
        CM_LOOKUP = 2'b00,
        CM_RAM    = 2'b01,
        CM_SHIFT  = 2'b10,
        CM_RSVD   = 2'b11
    } cell_mode_e;

    // Per-cycle update request derived from mode and enable.
    typedef struct packed {
        logic wr;     // store din at the addressed location
        logic shift;  // move the whole chain up by one place
    } cell_op_t;

    // The reserved code falls back to the read-only table.
    function automatic cell_mode_e resolve_mode(input logic [1:0] raw);
        cell_mode_e m;
        m = cell_mode_e'(raw);
        if (m == CM_RSVD) m = CM_LOOKUP;
        return m;
    endfunction

endpackage

// File: rtl/lut_cell_mode_reg.sv
module lut_cell_mode_reg
    import lut_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    output cell_mode_e mode_o
);

    cell_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= resolve_mode(mode_i);
    end

    assign mode_o = mode_q;

    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q)); // R10

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_q != CM_RSVD); // R3

endmodule

// File: rtl/lut_cell_ctrl.sv
module lut_cell_ctrl
    import lut_cell_pkg::*;
(
    input  cell_mode_e mode_i,
    input  logic       wr_en_i,
    output cell_op_t   op_o
);

    always_comb begin
        op_o = '0;
        unique case (mode_i)
            CM_RAM:   op_o.wr    = wr_en_i;
            CM_SHIFT: op_o.shift = wr_en_i;
            default:  op_o       = '0;
        endcase
    end

endmodule

// File: rtl/lut_cell_array.sv
module lut_cell_array
    import lut_cell_pkg::*;
#(
    parameter int unsigned      DEPTH = 16,
    parameter int unsigned      AW    = $clog2(DEPTH),
    parameter logic [DEPTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  cell_op_t         op_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             din_i,
    output logic [DEPTH-1:0] bits_o
);

    logic [DEPTH-1:0] bits_q;
    logic [DEPTH-1:0] shift_src;

    // Source of each stage when shifting: serial input for stage 0,
    // the stage below otherwise.
    assign shift_src = {bits_q[DEPTH-2:0], din_i};

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        logic sel;
        assign sel = (addr_i == AW'(i));

        always_ff @(posedge clk) begin
            if (rst)                  bits_q[i] <= INIT[i];
            else if (op_i.shift)      bits_q[i] <= shift_src[i];
            else if (op_i.wr && sel)  bits_q[i] <= din_i;
        end
    end

    assign bits_o = bits_q;

    AST_RAM_STORE: assert property (@(posedge clk) disable iff (rst)
        op_i.wr |=> bits_q[$past(addr_i)] == $past(din_i)); // R4

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        op_i.shift |=> (bits_q[0] == $past(din_i)) &&
                       (bits_q[DEPTH-1:1] == $past(bits_q[DEPTH-2:0]))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!op_i.wr && !op_i.shift) |=> $stable(bits_q)); // R7

    AST_OP_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_i.wr, op_i.shift})); // R6

endmodule

// File: rtl/lut_cell_rdmux.sv
module lut_cell_rdmux #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] bits_i,
    input  logic [AW-1:0]    addr_i,
    output logic             dout_o,
    output logic             cascade_o
);

    assign dout_o    = bits_i[addr_i];
    assign cascade_o = bits_i[DEPTH-1];

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int unsigned      DEPTH = 16,
    parameter logic [DEPTH-1:0] INIT  = 16'hA5C3,
    localparam int unsigned     AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] addr_i,
    input  logic          din_i,
    input  logic          wr_en_i,
    output logic          dout_o,
    output logic          cascade_o
);

    cell_mode_e       mode_q;
    cell_op_t         op;
    logic [DEPTH-1:0] bits;

    lut_cell_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_i),
        .mode_o (mode_q)
    );

    lut_cell_ctrl u_ctrl (
        .mode_i  (mode_q),
        .wr_en_i (wr_en_i),
        .op_o    (op)
    );

    lut_cell_array #(.DEPTH(DEPTH), .AW(AW), .INIT(INIT)) u_array (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op),
        .addr_i (addr_i),
        .din_i  (din_i),
        .bits_o (bits)
    );

    lut_cell_rdmux #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .bits_i    (bits),
        .addr_i    (addr_i),
        .dout_o    (dout_o),
        .cascade_o (cascade_o)
    );

    AST_ROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CM_LOOKUP) |=> $stable(bits)); // R3

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (bits == INIT)); // R1

endmodule

// File: tb/lut_cell_tb.sv
module lut_cell_tb;

    localparam logic [15:0] INIT_V = 16'hA5C3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic [3:0] addr = 4'd0;
    logic       din = 1'b0;
    logic       we = 1'b0;
    logic       dout, casc;

    always #4 clk = ~clk;

    lut_cell #(.DEPTH(16), .INIT(INIT_V)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_i),
        .addr_i    (addr),
        .din_i     (din),
        .wr_en_i   (we),
        .dout_o    (dout),
        .cascade_o (casc)
    );

    typedef struct {
        logic  dout;
        logic  casc;
        string tag;
    } exp_t;

    exp_t        q[$];
    event        exp_ev;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [15:0] ref_m;
    logic [1:0]  ref_mode;

    task automatic push(input string tag);
        exp_t e;
        e.dout = ref_m[addr];
        e.casc = ref_m[15];
        e.tag  = tag;
        q.push_back(e);
        ->exp_ev;
    endtask

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            @(exp_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (dout !== e.dout || casc !== e.casc) begin
                    bad++;
                    $display("FAIL %s addr=%0d dout act=%b exp=%b cascade act=%b exp=%b",
                             e.tag, addr, dout, e.dout, casc, e.casc);
                end
            end
        end
    end

    task automatic reset_to(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; mode_i = m; we = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_m = INIT_V;
        ref_mode = (m == 2'b11) ? 2'b00 : m;
    endtask

    task automatic model_edge(input logic [3:0] a, input logic d);
        case (ref_mode)
            2'b01:   ref_m[a] = d;
            2'b10:   ref_m = {ref_m[14:0], d};
            default: ;
        endcase
    endtask

    task automatic step(input logic [3:0] a, input logic d, input logic w, input string tag);
        @(negedge clk);
        addr = a; din = d; we = w;
        @(posedge clk);
        if (w) model_edge(a, d);
        #2;
        push(tag);
    endtask

    task automatic peek(input logic [3:0] a, input string tag);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1;
        push(tag);
    endtask

    initial begin
        // R1: reset contents
        reset_to(2'b00);
        for (int i = 0; i < 16; i++) peek(i[3:0], "R1 reset load");
        // R2: address change mid-cycle
        @(negedge clk);
        addr = 4'd3; #1; push("R2 async read");
        addr = 4'd2; #1; push("R2 async read");

        // R3: lookup mode ignores writes
        for (int i = 0; i < 40; i++)
            step(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'b1, "R3 lookup ignores write");
        for (int i = 0; i < 16; i++) peek(i[3:0], "R3 lookup contents");
        reset_to(2'b11);
        for (int i = 0; i < 20; i++)
            step(4'($urandom_range(0, 15)), ~INIT_V[i % 16], 1'b1, "R3 reserved code as lookup");
        for (int i = 0; i < 16; i++) peek(i[3:0], "R3 reserved contents");

        // R4: RAM write visible only after edge
        reset_to(2'b01);
        @(negedge clk);
        addr = 4'd5; din = ~INIT_V[5]; we = 1'b1;
        #1; push("R4 before edge old value");
        @(posedge clk);
        model_edge(4'd5, ~INIT_V[5]);
        #2; push("R4 after edge new value");
        for (int i = 0; i < 16; i++) peek(i[3:0], "R5 other locations kept");
        for (int i = 0; i < 120; i++) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 15));
            step(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 RAM random");
            peek(4'($urandom_range(0, 15)), "R5 RAM random readback");
        end
        for (int i = 0; i < 10; i++)
            step(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'b0, "R7 RAM no enable");

        // R10: mode change after reset has no effect
        @(negedge clk);
        mode_i = 2'b10;
        for (int i = 0; i < 30; i++)
            step(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'b1, "R10 mode held as RAM");
        for (int i = 0; i < 16; i++) peek(i[3:0], "R10 RAM contents");

        // R6/R8/R9: shift mode, walking one with tap following it
        reset_to(2'b10);
        for (int k = 0; k < 16; k++)
            step(k[3:0], (k == 0), 1'b1, "R8 tap delay walking one");
        step(4'd0, 1'b0, 1'b1, "R9 cascade after 16 shifts");
        for (int i = 0; i < 150; i++) begin
            logic w;
            w = ($urandom_range(0, 3) != 0);
            step(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), w,
                 w ? "R6 shift random" : "R7 shift no enable");
            peek(4'd0, "R6 location 0 holds serial input");
            peek(4'($urandom_range(0, 15)), "R8 random tap R9");
        end

        @(negedge clk);
        we = 1'b0;
        #20;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule